// File: doc/BRIEF.md
# Data-Space Address Generator

This block turns a load, store or stack request into a data-space address for a small 8-bit core. A pointer-based request chooses one of three 16-bit pointers. Each pointer is formed from a pair of adjacent working registers. The request then applies one of four modes: plain, post-increment, pre-decrement, or an unsigned displacement. A direct request carries its full 16-bit address. A constant-table request reads program memory through the third pointer, and its result is meant for register 0. The block also holds an 8-bit stack pointer. It forms the push and pop addresses from that pointer and lets the I/O path load it.

Every data address is sorted into one of four regions of a single linear map: the working registers at the bottom, the I/O registers above them, the internal SRAM above those, and everything else as unmapped. The block also reports the offset within the chosen region. When a mode changes a pointer, the block outputs the new value and the low register index of that pointer's pair, so the register file can write it back. All results are registered and appear one clock after the request.

Top module: `dsaddr_gen`

## Requirements
- R1: While rst_n is low, and on the first sample after reset, acc_valid, req_bad, wb_en and acc_prog are 0, acc_region is 0 and sp_q equals SP_RESET (default 0xDF).
- R2: req_op encodings are 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement, 4 direct, 5 push, 6 pop and 7 program-memory read. req_ptr_sel encodings are 0 X, 1 Y, 2 Z and 3 none. For op 0, acc_addr is the selected pointer and wb_en stays 0.
- R3: For op 1, acc_addr is the selected pointer and wb_value is the pointer plus 1 (modulo 2^16), with wb_en=1.
- R4: For op 2, both acc_addr and wb_value are the pointer minus 1 (modulo 2^16), with wb_en=1.
- R5: For op 3 on Y or Z, acc_addr is the pointer plus the 6-bit unsigned req_disp and wb_en stays 0. A pointer mode that selects none, or op 3 that selects X, gives req_bad=1 with acc_valid=0 and wb_en=0.
- R6: For op 4, acc_addr equals req_direct and wb_en stays 0.
- R7: For every valid data access, acc_region is one-hot: bit0 for addresses 0x00-0x1F (offset = addr), bit1 for 0x20-0x5F (offset = addr-0x20), bit2 for 0x60-0xDF (offset = addr-0x60), and bit3 for any other address (offset 0).
- R8: For op 7, acc_prog=1, acc_addr equals ptr_z whatever req_ptr_sel is, acc_region=0 and wb_en=0.
- R9: Push addresses {0, SP} and then lowers SP by 1, wrapping 0x00 to 0xFF.
- R10: Pop raises SP by 1 and addresses the new value.
- R11: sp_ld_en loads sp_ld_val into SP. In the same cycle as a stack request, the load sets the new SP, while the address is still formed from the old SP.
- R12: Results appear on the clock after the request. With req_valid low, acc_valid, req_bad and wb_en are 0 on the next sample and SP does not move. When wb_en=1, wb_reg_lo is 26 for X, 28 for Y and 30 for Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Access kind (see R2) |
| req_ptr_sel | input | 2 | Pointer choice (see R2) |
| ptr_x | input | 16 | X pointer (registers 27:26) |
| ptr_y | input | 16 | Y pointer (registers 29:28) |
| ptr_z | input | 16 | Z pointer (registers 31:30) |
| req_disp | input | 6 | Unsigned displacement |
| req_direct | input | 16 | Direct address |
| sp_ld_en | input | 1 | Stack pointer load from I/O |
| sp_ld_val | input | 8 | Stack pointer load value |
| acc_valid | output | 1 | Access result valid |
| acc_addr | output | 16 | Final address |
| acc_prog | output | 1 | Address targets program memory |
| acc_region | output | 4 | One-hot region (see R7) |
| acc_offset | output | 7 | Offset within region |
| wb_en | output | 1 | Pointer writeback strobe |
| wb_reg_lo | output | 5 | Low register index of written pair |
| wb_value | output | 16 | Updated pointer value |
| req_bad | output | 1 | Illegal pointer/mode pairing |
| sp_q | output | 8 | Current stack pointer |

## Verification
The hardest case to reach is a stack request in the same cycle as a stack-pointer load. The address must come from the old pointer while the load sets the new one. The stimulus first loads SP to zero, then pushes to force the wrap to 0xFF, then pops back, and finally issues a push together with a load. The pointer modes are driven from a vector table. The unselected pointers hold a decoy value, and the selected pointer sits on each region edge (0x1F/0x20, 0x5F/0x60, 0xDF/0xE0) and on the 16-bit wrap in both directions.

// File: rtl/dsaddr_pkg.sv
package dsaddr_pkg;
  typedef enum logic [2:0] {
    OP_IND     = 3'd0,
    OP_POSTINC = 3'd1,
    OP_PREDEC  = 3'd2,
    OP_DISP    = 3'd3,
    OP_DIRECT  = 3'd4,
    OP_PUSH    = 3'd5,
    OP_POP     = 3'd6,
    OP_PRGZ    = 3'd7
  } acc_op_e;

  localparam int NPTR = 3;
  localparam int RGN_N = 4;
endpackage

// File: rtl/dsaddr_ptr_unit.sv
module dsaddr_ptr_unit
  import dsaddr_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DISP_W = 6
) (
  input  acc_op_e            op,
  input  logic [1:0]         sel,
  input  logic [PTR_W-1:0]   ptr_x,
  input  logic [PTR_W-1:0]   ptr_y,
  input  logic [PTR_W-1:0]   ptr_z,
  input  logic [DISP_W-1:0]  disp,
  input  logic [PTR_W-1:0]   direct,
  output logic [PTR_W-1:0]   eff_addr,
  output logic               wb_req,
  output logic [PTR_W-1:0]   wb_val,
  output logic               bad
);
  function automatic logic [PTR_W-1:0] f_step(input logic [PTR_W-1:0] p, input logic down);
    return down ? p - 1'b1 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] f_offset(input logic [PTR_W-1:0] p, input logic [DISP_W-1:0] q);
    return p + PTR_W'(q);
  endfunction

  logic [PTR_W-1:0] ptr_arr [NPTR];
  logic [PTR_W-1:0] masked  [NPTR];
  logic [NPTR-1:0]  hit;
  logic [PTR_W-1:0] cur;
  logic             ptr_mode;

  assign ptr_arr[0] = ptr_x;
  assign ptr_arr[1] = ptr_y;
  assign ptr_arr[2] = ptr_z;

  for (genvar g = 0; g < NPTR; g++) begin : g_sel
    assign hit[g]    = (sel == 2'(g));
    assign masked[g] = hit[g] ? ptr_arr[g] : '0;
  end

  always_comb begin
    cur = '0;
    for (int i = 0; i < NPTR; i++) cur = cur | masked[i];
  end

  assign ptr_mode = (op == OP_IND) || (op == OP_POSTINC) || (op == OP_PREDEC) || (op == OP_DISP);
  assign bad      = ptr_mode && ((hit == '0) || ((op == OP_DISP) && hit[0]));

  always_comb begin
    eff_addr = cur;
    wb_req   = 1'b0;
    wb_val   = cur;
    case (op)
      OP_POSTINC: begin
        wb_req = 1'b1;
        wb_val = f_step(cur, 1'b0);
      end
      OP_PREDEC: begin
        eff_addr = f_step(cur, 1'b1);
        wb_req   = 1'b1;
        wb_val   = eff_addr;
      end
      OP_DISP:   eff_addr = f_offset(cur, disp);
      OP_DIRECT: eff_addr = direct;
      OP_PRGZ:   eff_addr = ptr_z;
      default:   eff_addr = cur;
    endcase
  end

  always_comb begin
    if (op == OP_PREDEC && !bad)
      a_predec_match_r4: assert (f_step(eff_addr, 1'b0) == cur);
  end
endmodule

// File: rtl/dsaddr_region_dec.sv
module dsaddr_region_dec
  import dsaddr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int REG_CNT  = 32,
  parameter int IO_CNT   = 64,
  parameter int SRAM_CNT = 128,
  parameter int OFF_W    = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [RGN_N-1:0]  region,
  output logic [OFF_W-1:0]  offset
);
  localparam logic [31:0] IO_BASE   = 32'(REG_CNT);
  localparam logic [31:0] SRAM_BASE = 32'(REG_CNT + IO_CNT);
  localparam logic [31:0] SRAM_END  = 32'(REG_CNT + IO_CNT + SRAM_CNT);

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    if (a32 < IO_BASE) begin
      region = 4'b0001;
      offset = OFF_W'(a32);
    end else if (a32 < SRAM_BASE) begin
      region = 4'b0010;
      offset = OFF_W'(a32 - IO_BASE);
    end else if (a32 < SRAM_END) begin
      region = 4'b0100;
      offset = OFF_W'(a32 - SRAM_BASE);
    end else begin
      region = 4'b1000;
      offset = '0;
    end
  end
endmodule

// File: rtl/dsaddr_sp_unit.sv
module dsaddr_sp_unit #(
  parameter int              SP_W     = 8,
  parameter logic [SP_W-1:0] SP_RESET = 8'hDF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            ld_en,
  input  logic [SP_W-1:0] ld_val,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] stack_addr
);
  logic [SP_W-1:0] sp_inc, sp_dec;
  assign sp_inc     = sp_q + 1'b1;
  assign sp_dec     = sp_q - 1'b1;
  assign stack_addr = pop ? sp_inc : sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sp_q <= SP_RESET;
    else if (ld_en)  sp_q <= ld_val;
    else if (push)   sp_q <= sp_dec;
    else if (pop)    sp_q <= sp_inc;
  end

  p_push_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !ld_en) |=> (sp_q == $past(sp_q) - 1'b1));
  p_pop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !ld_en) |=> (sp_q == $past(sp_q) + 1'b1));
  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (sp_q == $past(ld_val)));
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !push && !pop) |=> $stable(sp_q));
endmodule

// File: rtl/dsaddr_gen.sv
module dsaddr_gen
  import dsaddr_pkg::*;
#(
  parameter int PTR_W    = 16,
  parameter int SP_W     = 8,
  parameter int DISP_W   = 6,
  parameter int REG_CNT  = 32,
  parameter int IO_CNT   = 64,
  parameter int SRAM_CNT = 128,
  parameter logic [SP_W-1:0] SP_RESET = 8'hDF,
  localparam int MAX_CNT = (SRAM_CNT > IO_CNT) ? ((SRAM_CNT > REG_CNT) ? SRAM_CNT : REG_CNT)
                                               : ((IO_CNT > REG_CNT) ? IO_CNT : REG_CNT),
  localparam int OFF_W   = $clog2(MAX_CNT),
  localparam int REG_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_ptr_sel,
  input  logic [PTR_W-1:0]  ptr_x,
  input  logic [PTR_W-1:0]  ptr_y,
  input  logic [PTR_W-1:0]  ptr_z,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [PTR_W-1:0]  req_direct,
  input  logic              sp_ld_en,
  input  logic [SP_W-1:0]   sp_ld_val,
  output logic              acc_valid,
  output logic [PTR_W-1:0]  acc_addr,
  output logic              acc_prog,
  output logic [RGN_N-1:0]  acc_region,
  output logic [OFF_W-1:0]  acc_offset,
  output logic              wb_en,
  output logic [REG_W-1:0]  wb_reg_lo,
  output logic [PTR_W-1:0]  wb_value,
  output logic              req_bad,
  output logic [SP_W-1:0]   sp_q
);
  localparam int PAIR_BASE = REG_CNT - 2 * NPTR;

  acc_op_e          op;
  logic [PTR_W-1:0] ptr_addr, wb_val_c, final_addr;
  logic             wb_req_c, bad_c, is_stack, is_push, is_pop, is_prog;
  logic [SP_W-1:0]  stack_addr;
  logic [RGN_N-1:0] region_c;
  logic [OFF_W-1:0] offset_c;

  assign op       = acc_op_e'(req_op);
  assign is_push  = req_valid && (op == OP_PUSH);
  assign is_pop   = req_valid && (op == OP_POP);
  assign is_stack = (op == OP_PUSH) || (op == OP_POP);
  assign is_prog  = (op == OP_PRGZ);

  dsaddr_ptr_unit #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_ptr (
    .op(op), .sel(req_ptr_sel), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .disp(req_disp), .direct(req_direct), .eff_addr(ptr_addr),
    .wb_req(wb_req_c), .wb_val(wb_val_c), .bad(bad_c)
  );

  dsaddr_sp_unit #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .push(is_push), .pop(is_pop),
    .ld_en(sp_ld_en), .ld_val(sp_ld_val), .sp_q(sp_q), .stack_addr(stack_addr)
  );

  assign final_addr = is_stack ? {{(PTR_W-SP_W){1'b0}}, stack_addr} : ptr_addr;

  dsaddr_region_dec #(
    .ADDR_W(PTR_W), .REG_CNT(REG_CNT), .IO_CNT(IO_CNT), .SRAM_CNT(SRAM_CNT), .OFF_W(OFF_W)
  ) u_rgn (
    .addr(final_addr), .region(region_c), .offset(offset_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid  <= 1'b0;
      acc_addr   <= '0;
      acc_prog   <= 1'b0;
      acc_region <= '0;
      acc_offset <= '0;
      wb_en      <= 1'b0;
      wb_reg_lo  <= '0;
      wb_value   <= '0;
      req_bad    <= 1'b0;
    end else begin
      acc_valid  <= req_valid && !bad_c;
      req_bad    <= req_valid && bad_c;
      acc_addr   <= final_addr;
      acc_prog   <= req_valid && !bad_c && is_prog;
      acc_region <= (req_valid && !bad_c && !is_prog) ? region_c : '0;
      acc_offset <= (req_valid && !bad_c && !is_prog) ? offset_c : '0;
      wb_en      <= req_valid && !bad_c && wb_req_c;
      wb_reg_lo  <= REG_W'(PAIR_BASE + 2 * int'(req_ptr_sel));
      wb_value   <= wb_val_c;
    end
  end

  p_region_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_prog) |-> ($countones(acc_region) == 1));
  p_prog_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_prog |-> (acc_region == '0 && !wb_en));
  p_bad_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_bad |-> (!acc_valid && !wb_en));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!acc_valid && !req_bad && !wb_en));
  p_wb_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!wb_en || $past(req_op) == 3'd1 || $past(req_op) == 3'd2));
endmodule

// File: tb/sim_dsaddr_gen.sv
module sim_dsaddr_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_ptr_sel = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0, req_direct = '0;
  logic [5:0] req_disp = '0;
  logic sp_ld_en = 1'b0;
  logic [7:0] sp_ld_val = '0;
  logic acc_valid, acc_prog, wb_en, req_bad;
  logic [15:0] acc_addr, wb_value;
  logic [3:0] acc_region;
  logic [6:0] acc_offset;
  logic [4:0] wb_reg_lo;
  logic [7:0] sp_q;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  dsaddr_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_ptr_sel(req_ptr_sel),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .req_disp(req_disp), .req_direct(req_direct),
    .sp_ld_en(sp_ld_en), .sp_ld_val(sp_ld_val), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_prog(acc_prog), .acc_region(acc_region), .acc_offset(acc_offset), .wb_en(wb_en),
    .wb_reg_lo(wb_reg_lo), .wb_value(wb_value), .req_bad(req_bad), .sp_q(sp_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_rgn(input logic [15:0] a);
    if (a < 16'd32) return 4'b0001;
    if (a < 16'd96) return 4'b0010;
    if (a < 16'd224) return 4'b0100;
    return 4'b1000;
  endfunction

  function automatic logic [6:0] exp_off(input logic [15:0] a);
    if (a < 16'd32) return a[6:0];
    if (a < 16'd96) return 7'(a - 16'd32);
    if (a < 16'd224) return 7'(a - 16'd96);
    return 7'd0;
  endfunction

  function automatic string op_tag(input logic [2:0] op, input bit bad);
    if (bad) return "R5";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R8";
    endcase
  endfunction

  // op, sel, ptr, disp, direct, exp_addr, exp_wb, exp_wbv, exp_bad
  localparam int NV = 14;
  localparam logic [76:0] VEC [NV] = '{
    {3'd0, 2'd0, 16'h0010, 6'd0,  16'h0000, 16'h0010, 1'b0, 16'h0000, 1'b0},
    {3'd0, 2'd1, 16'h0035, 6'd0,  16'h0000, 16'h0035, 1'b0, 16'h0000, 1'b0},
    {3'd1, 2'd2, 16'h0060, 6'd0,  16'h0000, 16'h0060, 1'b1, 16'h0061, 1'b0},
    {3'd1, 2'd0, 16'hFFFF, 6'd0,  16'h0000, 16'hFFFF, 1'b1, 16'h0000, 1'b0},
    {3'd2, 2'd1, 16'h0020, 6'd0,  16'h0000, 16'h001F, 1'b1, 16'h001F, 1'b0},
    {3'd2, 2'd2, 16'h0000, 6'd0,  16'h0000, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0},
    {3'd3, 2'd1, 16'h0050, 6'd63, 16'h0000, 16'h008F, 1'b0, 16'h0000, 1'b0},
    {3'd3, 2'd2, 16'h00A0, 6'd63, 16'h0000, 16'h00DF, 1'b0, 16'h0000, 1'b0},
    {3'd3, 2'd2, 16'h00A1, 6'd63, 16'h0000, 16'h00E0, 1'b0, 16'h0000, 1'b0},
    {3'd3, 2'd0, 16'h0040, 6'd1,  16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1},
    {3'd4, 2'd0, 16'h0000, 6'd0,  16'h005F, 16'h005F, 1'b0, 16'h0000, 1'b0},
    {3'd4, 2'd3, 16'h0000, 6'd0,  16'h0100, 16'h0100, 1'b0, 16'h0000, 1'b0},
    {3'd0, 2'd3, 16'h0000, 6'd0,  16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1},
    {3'd7, 2'd0, 16'h0123, 6'd0,  16'h0000, 16'h0123, 1'b0, 16'h0000, 1'b0}
  };

  task automatic stack_op(input logic [2:0] op, input bit ld, input logic [7:0] ldv,
                          input logic [15:0] ea, input logic [7:0] esp, input string req);
    req_valid = 1'b1; req_op = op; sp_ld_en = ld; sp_ld_val = ldv;
    @(negedge clk);
    req_valid = 1'b0; sp_ld_en = 1'b0;
    chk(acc_valid && acc_addr == ea, req, 32'(acc_addr), 32'(ea));
    chk(acc_region == exp_rgn(ea) && acc_offset == exp_off(ea), req, 32'({acc_region, acc_offset}),
        32'({exp_rgn(ea), exp_off(ea)}));
    chk(sp_q == esp, req, 32'(sp_q), 32'(esp));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!acc_valid && !req_bad && !wb_en && !acc_prog && acc_region == 0, "R1",
        32'({acc_valid, req_bad, wb_en, acc_prog, acc_region}), 32'd0);
    chk(sp_q == 8'hDF, "R1", 32'(sp_q), 32'hDF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!acc_valid && sp_q == 8'hDF, "R1", 32'({acc_valid, sp_q}), 32'hDF);

    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      logic [2:0] op; logic [1:0] sel; logic [15:0] ea, wbv; logic ewb, ebad;
      string tag;
      v = VEC[i];
      op = v[76:74]; sel = v[73:72]; ea = v[33:18]; ewb = v[17]; wbv = v[16:1]; ebad = v[0];
      ptr_x = 16'hAAAA; ptr_y = 16'hAAAA; ptr_z = 16'hAAAA;
      if (op == 3'd7) ptr_z = v[71:56];
      else if (sel == 2'd0) ptr_x = v[71:56];
      else if (sel == 2'd1) ptr_y = v[71:56];
      else if (sel == 2'd2) ptr_z = v[71:56];
      req_op = op; req_ptr_sel = sel; req_disp = v[55:50]; req_direct = v[49:34];
      req_valid = 1'b1;
      tag = op_tag(op, ebad);
      @(negedge clk);
      chk(req_bad == ebad && acc_valid == !ebad, tag, 32'({req_bad, acc_valid}), 32'({ebad, !ebad}));
      chk(wb_en == ewb, tag, 32'(wb_en), 32'(ewb));
      if (!ebad) begin
        chk(acc_addr == ea, tag, 32'(acc_addr), 32'(ea));
        if (op == 3'd7) begin
          chk(acc_prog && acc_region == 0, "R8", 32'({acc_prog, acc_region}), 32'h10);
        end else begin
          chk(!acc_prog && acc_region == exp_rgn(ea), "R7", 32'(acc_region), 32'(exp_rgn(ea)));
          chk(acc_offset == exp_off(ea), "R7", 32'(acc_offset), 32'(exp_off(ea)));
        end
      end
      if (ewb) begin
        chk(wb_value == wbv, tag, 32'(wb_value), 32'(wbv));
        chk(wb_reg_lo == 5'(26 + 2 * sel), "R12", 32'(wb_reg_lo), 32'(26 + 2 * sel));
      end
    end

    // idle request: op push but not valid must not move SP
    req_valid = 1'b0; req_op = 3'd5;
    @(negedge clk);
    chk(!acc_valid && !req_bad && !wb_en, "R12", 32'({acc_valid, req_bad, wb_en}), 32'd0);
    chk(sp_q == 8'hDF, "R12", 32'(sp_q), 32'hDF);

    stack_op(3'd5, 1'b0, 8'h00, 16'h00DF, 8'hDE, "R9");
    stack_op(3'd6, 1'b0, 8'h00, 16'h00DF, 8'hDF, "R10");

    sp_ld_en = 1'b1; sp_ld_val = 8'h00;
    @(negedge clk);
    sp_ld_en = 1'b0;
    chk(sp_q == 8'h00 && !acc_valid, "R11", 32'(sp_q), 32'h00);

    stack_op(3'd5, 1'b0, 8'h00, 16'h0000, 8'hFF, "R9");
    stack_op(3'd6, 1'b0, 8'h00, 16'h0000, 8'h00, "R10");
    stack_op(3'd5, 1'b1, 8'h40, 16'h0000, 8'h40, "R11");
    stack_op(3'd6, 1'b0, 8'h00, 16'h0041, 8'h41, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule